// File: doc/BRIEF.md
# Table-Driven State Machine

This block is a general-purpose synchronous state machine. Its next-state and output functions are not built from gates. They are held in a small random-access table that can be rewritten. The external inputs and the registered present state are joined into a table address. The word read from that address holds the code of the following state and one bit for each output function. A state register feeds the stored state back into the address, which closes the loop.

Before operation the table is loaded through a plain write port while `run` is low. A second, smaller table is addressed by the present state alone and supplies outputs in state-only (Moore) form. A mode pin selects between those outputs and the outputs taken from the input-plus-state word (Mealy form). Any behaviour that fits the table sizes can be loaded, for example a Gray-coded up/down counter with binary outputs. Every pin is plain control or status. There is no streaming data path, so no valid/ready handshake and no back-pressure applies.

Top module: `fsm_lut_top`

## Requirements
- R1: A synchronous active-low reset (`rst_n`) sets the state register to code 0, and `state_o` reads 0 after a reset edge.
- R2: While `run` is high, each rising clock edge loads `state_o` with the upper ST_W bits of the transition word at address `{in_x, state_o}`. With the defaults this is word bits [3:2], and `in_x` is the most significant address bit.
- R3: While `run` is low, `state_o` does not change, whatever `in_x` does.
- R4: A write request (`wr_en` high) made while `run` is high is ignored and leaves both tables unchanged.
- R5: In Mealy mode (`mealy_mode`=1), `out_y` equals the low OUT_W bits of the transition word at `{in_x, state_o}`. It follows a change of `in_x` within the same cycle, with no clock edge needed.
- R6: In Moore mode (`mealy_mode`=0), `out_y` is the state-table entry for `state_o` and does not depend on `in_x`.
- R7: With `run` low, `wr_en`=1 and `wr_moore`=1, the state-only table entry at `wr_addr[ST_W-1:0]` takes `wr_data[OUT_W-1:0]`. With `wr_moore`=0, the transition word at `wr_addr` takes all of `wr_data`. Each write is visible from the next cycle.
- R8: Every one of the 2^(IN_W+ST_W) transition locations can be written and read on its own. Once loaded with the Gray up/down counter (up when `in_x`=1: 0,1,3,2; down in reverse), the machine follows that sequence, and its outputs give the binary count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High: state advances; low: state holds and writes allowed |
| mealy_mode | input | 1 | 1 selects input-plus-state outputs, 0 state-only outputs |
| in_x | input | IN_W | External machine inputs |
| wr_en | input | 1 | Table write strobe |
| wr_moore | input | 1 | 1 targets the state-only table, 0 the transition table |
| wr_addr | input | IN_W+ST_W | Write address |
| wr_data | input | ST_W+OUT_W | Write word {next state, outputs} |
| state_o | output | ST_W | Present state code |
| out_y | output | OUT_W | Machine outputs |

## Verification
On every cycle the assertions check the reset value of the state, that the state holds while `run` is low, that each advance takes the next-state field read in the previous cycle, and that Moore outputs stay put while the state and tables do. The bench scenarios are the only way to show that writes made while running are dropped, that Mealy outputs react to the input within a cycle, and that a loaded Gray counter table gives the right count sequence in both directions.

// File: rtl/fsm_lut_pkg.sv
package fsm_lut_pkg;
  typedef enum logic {OUT_MOORE = 1'b0, OUT_MEALY = 1'b1} out_mode_e;
  typedef enum logic {TBL_TRANS = 1'b0, TBL_STATE = 1'b1} tbl_sel_e;
endpackage

// File: rtl/fsm_lut_ram.sv
module fsm_lut_ram #(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fsm_state_reg.sv
module fsm_state_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (adv) q <= d;
  end
endmodule

// File: rtl/fsm_lut_top.sv
module fsm_lut_top
  import fsm_lut_pkg::*;
#(
  parameter int IN_W  = 1,
  parameter int ST_W  = 2,
  parameter int OUT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   mealy_mode,
  input  logic [IN_W-1:0]        in_x,
  input  logic                   wr_en,
  input  logic                   wr_moore,
  input  logic [IN_W+ST_W-1:0]   wr_addr,
  input  logic [ST_W+OUT_W-1:0]  wr_data,
  output logic [ST_W-1:0]        state_o,
  output logic [OUT_W-1:0]       out_y
);
  localparam int ADDR_W = IN_W + ST_W;
  localparam int WORD_W = ST_W + OUT_W;

  tbl_sel_e  wsel;
  out_mode_e omode;
  logic      load_ok;
  logic      we_trans, we_state;

  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] tr_word;
  logic [ST_W-1:0]   nxt_st;
  logic [OUT_W-1:0]  mealy_y, moore_y;

  assign wsel    = tbl_sel_e'(wr_moore);
  assign omode   = out_mode_e'(mealy_mode);
  assign load_ok = wr_en && !run;
  assign we_trans = load_ok && (wsel == TBL_TRANS);
  assign we_state = load_ok && (wsel == TBL_STATE);

  assign rd_addr = {in_x, state_o};

  fsm_lut_ram #(.AW(ADDR_W), .DW(WORD_W)) u_trans (
    .clk   (clk),
    .we    (we_trans),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (tr_word)
  );

  fsm_lut_ram #(.AW(ST_W), .DW(OUT_W)) u_stout (
    .clk   (clk),
    .we    (we_state),
    .waddr (wr_addr[ST_W-1:0]),
    .wdata (wr_data[OUT_W-1:0]),
    .raddr (state_o),
    .rdata (moore_y)
  );

  assign nxt_st  = tr_word[WORD_W-1:OUT_W];
  assign mealy_y = tr_word[OUT_W-1:0];

  fsm_state_reg #(.W(ST_W)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (run),
    .d     (nxt_st),
    .q     (state_o)
  );

  always_comb begin
    case (omode)
      OUT_MEALY: out_y = mealy_y;
      default:   out_y = moore_y;
    endcase
  end
endmodule

// File: rtl/fsm_lut_chk.sv
module fsm_lut_chk #(
  parameter int ST_W  = 2,
  parameter int OUT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             mealy_mode,
  input logic             wr_en,
  input logic [ST_W-1:0]  state_o,
  input logic [OUT_W-1:0] out_y,
  input logic [ST_W-1:0]  nxt_field
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (state_o == '0));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(state_o));

  // R2
  advance_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (state_o == $past(nxt_field)));

  // R6
  moore_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mealy_mode && !$past(mealy_mode) && $stable(state_o) && !$past(wr_en))
      |-> $stable(out_y));
endmodule

bind fsm_lut_top fsm_lut_chk #(.ST_W(ST_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .mealy_mode (mealy_mode),
  .wr_en      (wr_en),
  .state_o    (state_o),
  .out_y      (out_y),
  .nxt_field  (nxt_st)
);

// File: tb/fsm_lut_top_bench.sv
module fsm_lut_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       mealy_mode = 1'b0;
  logic [0:0] in_x = '0;
  logic       wr_en = 1'b0;
  logic       wr_moore = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [1:0] state_o;
  logic [1:0] out_y;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsm_lut_top u_fsm_lut_top (
    .clk(clk), .rst_n(rst_n), .run(run), .mealy_mode(mealy_mode),
    .in_x(in_x), .wr_en(wr_en), .wr_moore(wr_moore), .wr_addr(wr_addr),
    .wr_data(wr_data), .state_o(state_o), .out_y(out_y)
  );

  typedef struct {
    logic [1:0] st;
    logic [1:0] y;
    bit         chk_y;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  // Bench model of the requirements
  logic [3:0] m_tr [8];
  logic [1:0] m_so [4];
  logic [1:0] m_st = '0;

  function automatic logic [1:0] gray_next(logic [1:0] s, logic up);
    case (s)
      2'b00: return up ? 2'b01 : 2'b10;
      2'b01: return up ? 2'b11 : 2'b00;
      2'b11: return up ? 2'b10 : 2'b01;
      default: return up ? 2'b00 : 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] gray_bin(logic [1:0] s);
    case (s)
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      2'b11: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic cyc(input logic x, input logic r, input logic mm,
                     input logic we, input logic wm, input logic [2:0] wa,
                     input logic [3:0] wd, input bit cy, input string tag);
    exp_t e;
    @(negedge clk);
    in_x = x; run = r; mealy_mode = mm;
    wr_en = we; wr_moore = wm; wr_addr = wa; wr_data = wd;
    e.st = m_st;
    e.y = mm ? m_tr[{x, m_st}][1:0] : m_so[m_st];
    e.chk_y = cy;
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    if (we && !r) begin
      if (wm) m_so[wa[1:0]] = wd[1:0];
      else    m_tr[wa] = wd;
    end
    if (r) m_st = m_tr[{x, m_st}][3:2];
  endtask

  // Monitor: compares outputs after inputs have settled
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (state_o !== e.st) begin
        errors++;
        $display("FAIL %s state act=%0h exp=%0h", e.tag, state_o, e.st);
      end
      if (e.chk_y) begin
        checks++;
        if (out_y !== e.y) begin
          errors++;
          $display("FAIL %s out act=%0h exp=%0h", e.tag, out_y, e.y);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_tr[i]) m_tr[i] = '0;
    foreach (m_so[i]) m_so[i] = '0;
    // R1: state is zero under reset, even with run high
    rst_n = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0, "R1");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R8 / R7: load every transition location and the state-only table
    for (int a = 0; a < 8; a++) begin
      logic [1:0] n;
      logic [2:0] aa;
      aa = 3'(a);
      n = gray_next(aa[1:0], aa[2]);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, aa, {n, gray_bin(n)}, 1'b0, "R8");
    end
    for (int s = 0; s < 4; s++)
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'(s), {2'b00, gray_bin(2'(s))}, 1'b0, "R7");

    // R2 / R8: Mealy mode counting up, then down, then alternating
    for (int i = 0; i < 6; i++)
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R2");
    for (int i = 0; i < 5; i++)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R8");
    for (int i = 0; i < 4; i++)
      cyc(1'(i), 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R2");

    // R5: Mealy output follows the input without a state change
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R5");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R5");

    // R3: idle with input toggling
    for (int i = 0; i < 3; i++)
      cyc(1'(i), 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R3");

    // R6: Moore mode counting, then idle with input toggling
    for (int i = 0; i < 5; i++)
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R6");
    for (int i = 0; i < 3; i++)
      cyc(1'(i), 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R6");

    // R4: writes while running are dropped (both tables targeted)
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, {1'b0, m_st}, 4'b1111, 1'b1, "R4");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, {1'b1, m_st}, 4'b0000, 1'b1, "R4");
    for (int i = 0; i < 5; i++)
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R4");
    for (int i = 0; i < 4; i++)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R4");

    // R7: rewrite the state-only entry of the present state while idle
    begin
      logic [1:0] keep;
      keep = m_so[m_st];
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, {1'b0, m_st}, {2'b00, ~keep}, 1'b1, "R7");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R7");
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, {1'b0, m_st}, {2'b00, keep}, 1'b1, "R7");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R7");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule